// File: doc/BRIEF.md
# Fractional Clock Divider with Error Accumulation

This block derives a square-wave output clock from its input clock so that the ratio of input frequency to output frequency is the rational number N/M. The output frequency is therefore f_in·M/N. Every output half period is a whole number of input cycles. A remainder accumulator decides, half period by half period, whether that half period gets one extra input cycle. The long-run average is exact, and no output edge strays more than one input cycle from its ideal position. When N is a multiple of 2·M there is nothing to accumulate, and every half period has the same length.

The ratio is loaded at reset. While the synchronous reset is high, the block captures `ratio_n` and `ratio_m`. After reset is released, a bit-serial divider takes NW cycles to find the base half period ⌊N/(2M)⌋ and the remainder N mod 2M. The ratio is then checked. A legal ratio starts the output. An illegal ratio keeps the output low until the next reset. The ratio is reduced offline, before it is applied.

Top module: `fdiv_bresenham_clk`

## Requirements
- R1: While reset is high, and after reset until the first half period completes, `clk_out` is low.
- R2: The base half period is ⌊N/(2M)⌋ input cycles. When N mod 2M is 0, every half period equals that base.
- R3: Each output half period (the run of consecutive input cycles with `clk_out` constant) lasts either the base length or the base length plus one.
- R4: Any window of 2·M consecutive output half periods spans exactly N input cycles, so the average ratio is exactly N/M.
- R5: The accumulator starts at 0 at reset. At each output toggle, the remainder is added to it. If the sum reaches 2·M or more, 2·M is subtracted and the half period that starts at that toggle is one cycle longer. The half period that starts at the first rising edge is the first one to use this rule.
- R6: If `ratio_m` is 0 or above 32767 (bit 15 set), the ratio is rejected and `clk_out` stays low until the next reset.
- R7: If the base half period is below 7 or above 262000 input cycles, the ratio is rejected and `clk_out` stays low until the next reset. A base of exactly 7 is accepted.
- R8: Changes on `ratio_n` and `ratio_m` while reset is low have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high; captures the ratio |
| ratio_n | input | 32 | Numerator N of f_in/f_out |
| ratio_m | input | 16 | Denominator M of f_in/f_out |
| clk_out | output | 1 | Divided square-wave output |

## Verification
The assertions rely on two things. The ratio inputs matter only while reset is high. The accumulator bound and the half-period bound hold only when the ratio passed its checks. The divider's identity, base·2M + remainder = N, is asserted only for M ≠ 0. The bench applies every ratio under reset and holds reset for several cycles. Each legal ratio it uses gives a base of at least 7, so each half period is long enough to be measured.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned FD_NW       = 32;      // numerator width
  localparam int unsigned FD_MW       = 16;      // denominator width
  localparam int unsigned FD_MIN_HALF = 7;       // shortest legal half period
  localparam int unsigned FD_MAX_HALF = 262000;  // longest legal half period
  localparam int unsigned FD_HW       = $clog2(FD_MAX_HALF + 2);

  typedef enum logic [1:0] {
    SOLVE_BUSY  = 2'd0,
    SOLVE_DONE  = 2'd1
  } solve_state_e;
endpackage

// File: rtl/fdiv_ratio_solver.sv
module fdiv_ratio_solver #(
  parameter int unsigned NW       = 32,
  parameter int unsigned MW       = 16,
  parameter int unsigned MIN_HALF = 7,
  parameter int unsigned MAX_HALF = 262000,
  parameter int unsigned HW       = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] ratio_n,
  input  logic [MW-1:0] ratio_m,
  output logic          done,
  output logic          valid,
  output logic [HW-1:0] base,
  output logic [MW:0]   rest,
  output logic [MW:0]   twom
);
  import fdiv_pkg::*;
  localparam int unsigned SW = $clog2(NW);

  solve_state_e   state;
  logic [NW-1:0]  n_q;
  logic [MW-1:0]  m_q;
  logic [SW-1:0]  step;
  logic [MW:0]    rem_q;
  logic [NW-1:0]  quo_q;
  logic [MW+1:0]  trial, div_x, trial_sub;
  logic           fits, m_ok, range_ok;

  assign twom      = {m_q, 1'b0};
  assign div_x     = {1'b0, twom};
  assign trial     = {rem_q, n_q[NW-1-int'(step)]};
  assign fits      = trial >= div_x;
  assign trial_sub = trial - div_x;

  // Restoring division, one quotient bit per cycle, MSB first
  always_ff @(posedge clk) begin
    if (rst) begin
      n_q   <= ratio_n;
      m_q   <= ratio_m;
      step  <= '0;
      rem_q <= '0;
      quo_q <= '0;
      state <= SOLVE_BUSY;
    end else if (state == SOLVE_BUSY) begin
      rem_q <= fits ? trial_sub[MW:0] : trial[MW:0];
      quo_q <= {quo_q[NW-2:0], fits};
      step  <= step + 1'b1;
      if (step == SW'(NW - 1)) state <= SOLVE_DONE;
    end
  end

  assign m_ok     = (m_q != '0) && !m_q[MW-1];
  assign range_ok = (quo_q >= NW'(MIN_HALF)) && (quo_q <= NW'(MAX_HALF));
  assign done     = (state == SOLVE_DONE);
  assign valid    = done && m_ok && range_ok;
  assign base     = quo_q[HW-1:0];
  assign rest     = rem_q;

  // R2: the finished division reproduces the captured numerator
  p_quotient_exact_r2: assert property (@(posedge clk) disable iff (rst)
    (done && m_q != '0) |->
      ((64'(quo_q) * 64'(twom) + 64'(rem_q)) == 64'(n_q)) && (rem_q < twom));

  // R8: captured ratio does not move outside reset
  p_ratio_held_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(n_q) && $stable(m_q)));
endmodule

// File: rtl/fdiv_edge_timer.sv
module fdiv_edge_timer #(
  parameter int unsigned MW = 16,
  parameter int unsigned HW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [HW-1:0] base,
  input  logic [MW:0]   rest,
  input  logic [MW:0]   twom,
  output logic          clk_out
);
  logic          running;
  logic [HW-1:0] cnt;
  logic [MW:0]   acc;
  logic [MW+1:0] acc_sum, acc_wrap;
  logic          extra, expire;

  assign acc_sum  = {1'b0, acc} + {1'b0, rest};
  assign extra    = acc_sum >= {1'b0, twom};
  assign acc_wrap = acc_sum - {1'b0, twom};
  assign expire   = running && (cnt == HW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      clk_out <= 1'b0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        cnt     <= base;
      end
    end else if (expire) begin
      clk_out <= ~clk_out;
      acc     <= extra ? acc_wrap[MW:0] : acc_sum[MW:0];
      cnt     <= base + HW'(extra);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5: error accumulator stays below the 2M wrap limit
  p_acc_bound_r5: assert property (@(posedge clk) disable iff (rst)
    running |-> (acc < twom));

  // R3: a half-period count never exceeds base plus one
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt != '0 && cnt <= base + HW'(1)));

  // R3: output holds while the count has not expired
  p_hold_until_expire_r3: assert property (@(posedge clk) disable iff (rst)
    (running && cnt != HW'(1)) |=> $stable(clk_out));
endmodule

// File: rtl/fdiv_bresenham_clk.sv
module fdiv_bresenham_clk #(
  parameter int unsigned NW       = fdiv_pkg::FD_NW,
  parameter int unsigned MW       = fdiv_pkg::FD_MW,
  parameter int unsigned MIN_HALF = fdiv_pkg::FD_MIN_HALF,
  parameter int unsigned MAX_HALF = fdiv_pkg::FD_MAX_HALF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] ratio_n,
  input  logic [MW-1:0] ratio_m,
  output logic          clk_out
);
  localparam int unsigned HW = $clog2(MAX_HALF + 2);

  logic          sol_done, sol_valid;
  logic [HW-1:0] sol_base;
  logic [MW:0]   sol_rest, sol_twom;

  fdiv_ratio_solver #(
    .NW(NW), .MW(MW), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF), .HW(HW)
  ) u_solver (
    .clk(clk), .rst(rst), .ratio_n(ratio_n), .ratio_m(ratio_m),
    .done(sol_done), .valid(sol_valid), .base(sol_base),
    .rest(sol_rest), .twom(sol_twom)
  );

  fdiv_edge_timer #(.MW(MW), .HW(HW)) u_timer (
    .clk(clk), .rst(rst), .start(sol_valid), .base(sol_base),
    .rest(sol_rest), .twom(sol_twom), .clk_out(clk_out)
  );

  // R6/R7: a rejected ratio never lets the output rise
  p_reject_low_r6: assert property (@(posedge clk) disable iff (rst)
    (sol_done && !sol_valid) |-> !clk_out);

  // R1: output is low until the divider has finished
  p_low_while_solving_r1: assert property (@(posedge clk) disable iff (rst)
    !sol_done |-> !clk_out);
endmodule

// File: tb/fdiv_bresenham_clk_test.sv
module fdiv_bresenham_clk_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ratio_n = 32'd100;
  logic [15:0] ratio_m = 16'd3;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  fdiv_bresenham_clk uut (
    .clk(clk), .rst(rst), .ratio_n(ratio_n), .ratio_m(ratio_m), .clk_out(clk_out)
  );

  int lens [0:4095];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [31:0] n, input logic [15:0] m);
    @(negedge clk);
    rst = 1'b1; ratio_n = n; ratio_m = m;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(clk_out == 1'b0, "R1 low in reset", clk_out, 0);
    end
    rst = 1'b0;
  endtask

  // Measure count half periods starting at the first rising edge
  task automatic measure(input int count, output bit ok);
    int guard = 0;
    int len;
    logic cur;
    ok = 1;
    while (clk_out !== 1'b1) begin
      @(negedge clk);
      guard++;
      if (guard > 20000) begin ok = 0; return; end
    end
    cur = 1'b1; len = 1;
    for (int k = 0; k < count; ) begin
      @(negedge clk);
      if (clk_out === cur) len++;
      else begin lens[k] = len; k++; len = 1; cur = clk_out; end
    end
  endtask

  // Full check of a legal ratio against the accumulator rule
  task automatic run_legal(input int n, input int m, input bit change_mid);
    int base, rest, twom, acc, halves, exp_len, sum, sum2, bad;
    bit ok;
    twom = 2 * m; base = n / twom; rest = n % twom;
    halves = 2 * twom + 1;
    apply_reset(n, m);
    if (change_mid) begin
      repeat (40) @(negedge clk);
      ratio_n = 32'd50; ratio_m = 16'd1;
    end
    measure(halves, ok);
    check(ok, "R2 output started", ok, 1);
    if (!ok) return;
    acc = 0; bad = 0;
    for (int k = 0; k < halves; k++) begin
      acc += rest;
      exp_len = base;
      if (acc >= twom) begin acc -= twom; exp_len = base + 1; end
      check(lens[k] == base || lens[k] == base + 1, "R3 half length range", lens[k], base);
      if (lens[k] != exp_len) begin
        bad++;
        check(0, change_mid ? "R8 sequence after input change" : "R5 sequence", lens[k], exp_len);
      end
    end
    check(bad == 0, change_mid ? "R8 all lengths" : "R5 all lengths", bad, 0);
    sum = 0; sum2 = 0;
    for (int k = 0; k < twom; k++) sum += lens[k];
    for (int k = 1; k <= twom; k++) sum2 += lens[k];
    check(sum == n, "R4 window sum", sum, n);
    check(sum2 == n, "R4 shifted window sum", sum2, n);
    if (rest == 0)
      for (int k = 0; k < halves; k++)
        check(lens[k] == base, "R2 integer ratio no jitter", lens[k], base);
  endtask

  // Rejected ratio: output must never rise
  task automatic run_illegal(input int n, input int m, input string req);
    bit seen = 0;
    apply_reset(n, m);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (clk_out !== 1'b0) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  task automatic test_reset_start();
    bit early = 0;
    apply_reset(32'd100, 16'd3);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clk_out !== 1'b0) early = 1;
    end
    check(!early, "R1 low before first half period", early, 0);
  endtask

  initial begin
    test_reset_start();
    run_legal(14, 1, 0);          // R7 lower bound accepted, base 7
    run_legal(200, 5, 0);         // R2 integer ratio
    run_legal(100, 3, 0);         // R5 base 16 rem 4
    run_legal(1000, 7, 0);        // R5 base 71 rem 6
    run_legal(11000, 310, 0);     // R4 larger M
    run_legal(100, 3, 1);         // R8 inputs change while running
    run_illegal(100, 0, "R6 M zero rejected");
    run_illegal(1000000, 32768, "R6 M above 32767 rejected");
    run_illegal(13, 1, "R7 base 6 rejected");
    run_illegal(524002, 1, "R7 base 262001 rejected");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule